// File: doc/BRIEF.md
# Interrupt entry sequencer

This block decides when a processor core may enter an interrupt and then carries out the entry. It holds a register of pending hardware sources and a latched reset request. When the global interrupt enable is set and no instruction skip is outstanding, it accepts one of them. The reset request goes first. Among hardware sources the lowest-numbered pending bit wins.

On acceptance the block captures the current program counter. It then writes that value to a byte-wide stack in data memory, one byte per clock, starting with the least significant byte. Each write goes to the address held by the external stack pointer, and the block pulses a decrement request alongside it. In the cycle after the last byte it presents the vector target as the new program counter and pulses a request to clear the global enable. The number of bytes pushed (1, 2 or 3) and the vector slot size (1 or 2 words) are parameters.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle. busy, mem_we, sp_dec, pc_load, gie_clr and irq_req are all 0, and no source is pending.
- R2: While skip_pend is high, no request is accepted: busy stays 0 and no memory write is issued.
- R3: While gie is low, neither a hardware source nor a reset request is accepted.
- R4: A pulse on rst_req is latched. When it is pending it is taken ahead of any hardware source, uses vector 0 (new PC 0), and does not clear any hardware pending bit.
- R5: A pulse on bit k of irq_set marks source k pending. When several are pending, the lowest k is serviced. Its vector number is k+1, and the new PC is (k+1)*2 when LONG_JMP=1, or k+1 otherwise.
- R6: After acceptance, exactly RET_BYTES consecutive cycles each carry mem_we=1 and sp_dec=1. Byte i of the return PC (bits 8i+7..8i) goes out in the i-th of these cycles, starting with i=0. mem_addr equals the stack pointer input in each of them.
- R7: The return PC is the value of pc_cur in the accepting cycle. Later changes of pc_cur do not alter the pushed bytes.
- R8: pc_load and gie_clr are high for exactly one cycle: the cycle right after the final push. pc_new carries the target in that cycle.
- R9: At acceptance of a hardware source, the lowest set pending bit is cleared. irq_req is high exactly while any hardware bit remains pending.
- R10: busy is high from the cycle after acceptance through the pc_load cycle. No new acceptance happens while busy, even with gie high and sources pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Reset-vector request pulse, latched |
| irq_set | input | NSRC | Per-source pending set pulses |
| gie | input | 1 | Global interrupt enable |
| skip_pend | input | 1 | Instruction skip outstanding; blocks acceptance |
| pc_cur | input | PCW | Current program counter (word address) |
| sp | input | SPW | Current stack pointer |
| sp_dec | output | 1 | Decrement the stack pointer this cycle |
| mem_we | output | 1 | Data memory byte write enable |
| mem_addr | output | SPW | Data memory byte address |
| mem_wdata | output | 8 | Data memory write byte |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | PCW | Vector target address |
| gie_clr | output | 1 | Clear the global interrupt enable |
| irq_req | output | 1 | At least one hardware source pending |
| busy | output | 1 | Entry sequence in progress |

## Verification
The bench walks a table of pending-source masks and checks the winner for each, including the all-ones mask and masks whose lowest bit is not bit 0. A design that scanned from the top, or put source k at slot k, would produce the wrong pc_new. The bench also checks the byte order and the addresses on the memory port. It changes pc_cur during the push, so a design that reads the live PC, reverses the byte order or skips the pointer decrement writes the wrong bytes. Directed cases cover entry attempted with skip_pend high, attempted with gie low, and a reset request racing a hardware source. That last case catches a design that services the hardware source or drops its pending bit. A back-to-back case holds gie high across two entries, so a design that accepts again while busy breaks the single-write-per-cycle sequence.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NSRC      = 8,
  parameter int PCW       = 22,
  parameter int SPW       = 16,
  parameter int RET_BYTES = 3,
  parameter bit LONG_JMP  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic [NSRC-1:0] irq_set,
  input  logic            gie,
  input  logic            skip_pend,
  input  logic [PCW-1:0]  pc_cur,
  input  logic [SPW-1:0]  sp,
  output logic            sp_dec,
  output logic            mem_we,
  output logic [SPW-1:0]  mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            pc_load,
  output logic [PCW-1:0]  pc_new,
  output logic            gie_clr,
  output logic            irq_req,
  output logic            busy
);
  localparam int VW = $clog2(NSRC + 1);
  localparam int CW = (RET_BYTES > 1) ? $clog2(RET_BYTES) : 1;
  localparam int SH = LONG_JMP ? 1 : 0;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_LOAD} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [23:0]     ret;
  logic [VW-1:0]   vec;
  logic [NSRC-1:0] pend;
  logic            rst_pend;
  logic [VW-1:0]   lo_idx;
  logic            take;

  always_comb begin
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) lo_idx = VW'(i);
  end

  assign take = (state == S_IDLE) && gie && !skip_pend && (rst_pend || (|pend));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ret      <= '0;
      vec      <= '0;
      pend     <= '0;
      rst_pend <= 1'b0;
    end else begin
      rst_pend <= rst_req | (rst_pend & ~take);
      if (take && !rst_pend) pend <= (pend & (pend - 1'b1)) | irq_set;
      else                   pend <= pend | irq_set;
      case (state)
        S_IDLE: if (take) begin
          state <= S_PUSH;
          cnt   <= '0;
          ret   <= 24'(pc_cur);
          vec   <= rst_pend ? '0 : lo_idx + VW'(1);
        end
        S_PUSH: begin
          if (cnt == CW'(RET_BYTES - 1)) state <= S_LOAD;
          cnt <= cnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_we    = (state == S_PUSH);
  assign sp_dec    = mem_we;
  assign mem_addr  = sp;
  assign mem_wdata = (cnt == CW'(0)) ? ret[7:0] : (cnt == CW'(1)) ? ret[15:8] : ret[23:16];
  assign pc_load   = (state == S_LOAD);
  assign gie_clr   = pc_load;
  assign pc_new    = pc_load ? (PCW'(vec) << SH) : '0;
  assign busy      = (state != S_IDLE);
  assign irq_req   = |pend;

  logic [CW:0] wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)       wcnt <= '0;
    else if (pc_load) wcnt <= '0;
    else if (mem_we)  wcnt <= wcnt + 1'b1;
  end

  p_skip_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && skip_pend) |=> !busy);
  p_gie_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !gie) |=> !busy);
  p_push_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (wcnt == (CW+1)'(RET_BYTES)));
  p_load_after_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($past(mem_we) && !mem_we && gie_clr));
  p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  p_clear_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(rst_pend) && ($past(irq_set) == '0))
      |-> ($countones(pend) + 1 == $countones($past(pend))));
  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> busy);
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0;
  logic [7:0]  irq_set = '0;
  logic        gie = 1'b0;
  logic        skip_pend = 1'b0;
  logic [21:0] pc_cur = '0;
  logic [15:0] sp_m;
  logic        sp_dec, mem_we, pc_load, gie_clr, irq_req, busy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [21:0] pc_new;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_set(irq_set), .gie(gie),
    .skip_pend(skip_pend), .pc_cur(pc_cur), .sp(sp_m), .sp_dec(sp_dec),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
    .pc_new(pc_new), .gie_clr(gie_clr), .irq_req(irq_req), .busy(busy));

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_m <= 16'h08FF;
    else if (sp_dec) sp_m <= sp_m - 16'd1;
  end

  localparam logic [11:0] TV [6] = '{
    {8'h01, 4'd0}, {8'h80, 4'd7}, {8'h0C, 4'd2},
    {8'hFF, 4'd0}, {8'h50, 4'd4}, {8'h20, 4'd5}};

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_set = '0; rst_req = 1'b0; gie = 1'b0; skip_pend = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_src(input logic [7:0] m);
    irq_set = m;
    @(negedge clk);
    irq_set = '0;
  endtask

  // Called at a negedge where acceptance happens at the next posedge.
  task automatic run_entry(input int exp_pc, input bit keep_gie, input string tag);
    logic [15:0] sp0 = sp_m;
    logic [23:0] r = 24'(pc_cur);
    @(negedge clk);
    if (!keep_gie) gie = 1'b0;
    pc_cur = ~pc_cur;
    for (int b = 0; b < 3; b++) begin
      chk(mem_we && sp_dec && busy, {tag, " R6 write strobe"}, {mem_we, sp_dec, busy}, 3'b111);
      chk(mem_addr == sp0 - 16'(b), {tag, " R6 address"}, mem_addr, sp0 - 16'(b));
      chk(mem_wdata == r[8*b +: 8], {tag, " R6 R7 byte"}, mem_wdata, r[8*b +: 8]);
      @(negedge clk);
    end
    chk(pc_load && gie_clr && busy && !mem_we, {tag, " R8 load strobe"},
        {pc_load, gie_clr, busy, mem_we}, 4'b1110);
    chk(int'(pc_new) == exp_pc, {tag, " R5 target"}, pc_new, exp_pc);
    @(negedge clk);
    chk(!pc_load && !busy, {tag, " R8 R10 end"}, {pc_load, busy}, 0);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk({busy, mem_we, sp_dec, pc_load, gie_clr, irq_req} == 6'b0, "R1 reset state",
        {busy, mem_we, sp_dec, pc_load, gie_clr, irq_req}, 0);

    for (int t = 0; t < 6; t++) begin
      logic [7:0] m = TV[t][11:4];
      int k = int'(TV[t][3:0]);
      do_reset();
      set_src(m);
      chk(irq_req, "R9 irq_req set", irq_req, 1);
      pc_cur = 22'h2A_5C31 + 22'(t);
      gie = 1'b1;
      run_entry((k + 1) * 2, 1'b0, "R5 table");
      chk(irq_req == ((m & (m - 8'd1)) != 0), "R9 remaining pending", irq_req,
          (m & (m - 8'd1)) != 0);
    end

    do_reset();
    set_src(8'h08);
    skip_pend = 1'b1; gie = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_we, "R2 skip blocks", {busy, mem_we}, 0);
    end
    skip_pend = 1'b0;
    pc_cur = 22'h01_0203;
    run_entry(8, 1'b0, "R2 after skip");

    do_reset();
    set_src(8'h02);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_we, "R3 gie low blocks", {busy, mem_we}, 0);
    end
    pc_cur = 22'h3F_00AA;
    gie = 1'b1;
    run_entry(0, 1'b0, "R4 reset first");
    chk(irq_req, "R4 hw bit kept", irq_req, 1);
    gie = 1'b1;
    run_entry(4, 1'b0, "R4 hw after reset");
    chk(!irq_req, "R9 none left", irq_req, 0);

    do_reset();
    set_src(8'h21);
    pc_cur = 22'h12_3456;
    gie = 1'b1;
    run_entry(2, 1'b1, "R10 first");
    chk(irq_req, "R10 one left", irq_req, 1);
    run_entry(12, 1'b0, "R10 second");
    chk(!busy && !irq_req, "R10 idle", {busy, irq_req}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule